// File: doc/BRIEF.md
# Page Load and Program Timer

This block is a clock-synchronous model of the write path of a byte-wide, page-organised nonvolatile memory with a 15-bit byte address. The three active-low control lines (chip enable, output enable, write enable) and the address and data buses are sampled on the system clock. A write strobe exists only while chip enable and write enable are both low and output enable is high. The address is taken when the strobe opens and the data when it closes. Each accepted strobe drops one byte into a 64-byte page latch, in any order.

Loading ends when no new strobe begins within an idle window. A program period of fixed length then follows. At its end the whole page is written into a behavioural array at once. Bytes that were not loaded get the don't-care pattern all-ones and an indeterminate flag. Writes are blocked while the supply-good input is low, and for a lockout interval after it rises. Strobes that are too short are filtered out. A strobe that names a different page than the one that opened the window is dropped and raises a sticky error.

All intervals are counted in clock cycles and set by parameters. The behavioural array holds `MEM_PAGES` pages, and a page number selects its array slot modulo `MEM_PAGES`. A plain read port shows committed contents without any delay.

Top module: `page_program_timer`

## Requirements
- R1: A byte load happens only for a strobe during which `ce_n`=0, `we_n`=0 and `oe_n`=1. Holding `oe_n` low, or `ce_n` high, loads nothing and leaves `busy` low.
- R2: The byte address is the `addr` value sampled on the first clock on which the strobe is seen. The byte value is the `din` sampled on the last clock on which the strobe is seen.
- R3: `addr[5:0]` selects the byte in the page and `addr[14:6]` selects the page. Bytes may be loaded in any order. The array slot is the page number modulo `MEM_PAGES`.
- R4: The load window closes when no strobe is present for `IDLE_TO` consecutive cycles after the last accepted load. A new load before then restarts that count. `busy` falls exactly `IDLE_TO+PROG_CYC+2` cycles after the release of the last accepted strobe.
- R5: The program period lasts `PROG_CYC` cycles. The page is committed to the array in its last cycle, and `busy` is low from the next cycle on.
- R6: After a commit, each loaded byte reads back its value with `rd_undef`=0. Each unloaded byte of that page reads 8'hFF with `rd_undef`=1.
- R7: No load is accepted while `supply_ok` is low, nor within `LOCK_CYC` cycles after it rises.
- R8: A strobe seen on fewer than `MIN_W` clocks is ignored.
- R9: The page of the first accepted load fixes the page for the window. A load that names another page is dropped and sets `page_err`, which stays high until reset.
- R10: `busy` rises after the first accepted load and stays high until the program period ends. Strobes that arrive during the program period are ignored and do not open a new window.
- R11: After reset, `busy`=0 and `page_err`=0, and every array byte reads 8'hFF with `rd_undef`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply-good indication; low blocks programming |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page number above, byte offset in low PAGE_W bits |
| din | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address into the behavioural array |
| rd_data | output | DATA_W | Committed byte at `rd_addr` |
| rd_undef | output | 1 | High when the byte at `rd_addr` was left indeterminate |
| busy | output | 1 | Load window open or program period running |
| page_err | output | 1 | Sticky: a load named a page other than the window's page |

## Verification
The hardest case to reach from the ports is a strobe that arrives inside the program period. The bench times it from the release of the last load: it waits past the idle window, so the block is programming but `busy` has not yet fallen, and then drives a full-width strobe. The bench then checks three things: the falling edge of `busy` keeps its exact distance from the earlier release, `busy` stays low afterwards, and the offset the strobe named reads as indeterminate. The capture points are checked with one strobe whose address and data change halfway through it.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgm_state_e;
endpackage

// File: rtl/pgm_pin_sampler.sv
// Registers the pins, qualifies the strobe, captures address at its start
// and data at its end, and measures its width as a glitch filter.
module pgm_pin_sampler #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int MIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              strobe,
  output logic              end_ok,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  localparam int WID_W = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);

  logic              s_q, s_d;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic [WID_W-1:0]  wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q      <= 1'b0;
      s_d      <= 1'b0;
      a_q      <= '0;
      d_q      <= '0;
      wcnt     <= '0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      s_q <= !ce_n && !we_n && oe_n;
      s_d <= s_q;
      a_q <= addr;
      d_q <= din;
      if (s_q && !s_d) begin
        cap_addr <= a_q;
        wcnt     <= WID_W'(1);
      end else if (s_q && wcnt != WID_W'(MIN_W)) begin
        wcnt <= wcnt + 1'b1;
      end
      if (s_q) cap_data <= d_q;
    end
  end

  assign strobe = s_q;
  assign end_ok = !s_q && s_d && (wcnt >= WID_W'(MIN_W));
endmodule

// File: rtl/pgm_ctrl.sv
// Window/program sequencer with supply lockout and page lock.
module pgm_ctrl
  import pgm_pkg::*;
#(
  parameter int PG_W     = 9,
  parameter int IDLE_TO  = 30,
  parameter int PROG_CYC = 60,
  parameter int LOCK_CYC = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supply_ok,
  input  logic            strobe,
  input  logic            end_ok,
  input  logic [PG_W-1:0] cap_page,
  output pgm_state_e      state,
  output logic [PG_W-1:0] cur_page,
  output logic            accept,
  output logic            lat_we,
  output logic            commit,
  output logic            busy,
  output logic            page_err
);
  localparam int IDLE_CW = $clog2(IDLE_TO + 1);
  localparam int PROG_CW = $clog2(PROG_CYC + 1);
  localparam int LOCK_CW = $clog2(LOCK_CYC + 1);

  logic [IDLE_CW-1:0] idle_cnt;
  logic [PROG_CW-1:0] prog_cnt;
  logic [LOCK_CW-1:0] lock_cnt;
  logic               lock_ok;
  logic               same_pg;

  assign lock_ok = (lock_cnt == LOCK_CW'(LOCK_CYC));
  assign accept  = end_ok && lock_ok && (state != ST_PROG);
  assign same_pg = (state == ST_IDLE) || (cap_page == cur_page);
  assign lat_we  = accept && same_pg;
  assign commit  = (state == ST_PROG) && (prog_cnt == PROG_CW'(PROG_CYC - 1));
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_cnt <= '0;
    else if (!supply_ok) lock_cnt <= '0;
    else if (!lock_ok) lock_cnt <= lock_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_page <= '0;
      idle_cnt <= '0;
      prog_cnt <= '0;
      page_err <= 1'b0;
    end else begin
      if (accept && !same_pg) page_err <= 1'b1;
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_LOAD;
          cur_page <= cap_page;
          idle_cnt <= '0;
        end
        ST_LOAD: begin
          if (lat_we) begin
            idle_cnt <= '0;
          end else if (!strobe) begin
            if (idle_cnt == IDLE_CW'(IDLE_TO - 1)) begin
              state    <= ST_PROG;
              prog_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (commit) state <= ST_IDLE;
          else prog_cnt <= prog_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgm_page_latch.sv
// One data register and one loaded flag per byte of the page.
module pgm_page_latch #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [PAGE_W-1:0]            ofs,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         clr,
  output logic [(1<<PAGE_W)*DATA_W-1:0] lat_data,
  output logic [(1<<PAGE_W)-1:0]       lat_mask
);
  localparam int NB = 1 << PAGE_W;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    logic              ld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        ld_q   <= 1'b0;
      end else if (clr) begin
        ld_q <= 1'b0;
      end else if (we && ofs == PAGE_W'(b)) begin
        byte_q <= wdata;
        ld_q   <= 1'b1;
      end
    end
    assign lat_data[b*DATA_W +: DATA_W] = byte_q;
    assign lat_mask[b]                  = ld_q;
  end
endmodule

// File: rtl/pgm_mem_array.sv
// Behavioural array: commits a whole page at once, reads combinationally.
module pgm_mem_array #(
  parameter int ADDR_W    = 15,
  parameter int PAGE_W    = 6,
  parameter int DATA_W    = 8,
  parameter int MEM_PAGES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [ADDR_W-PAGE_W-1:0]      page,
  input  logic [(1<<PAGE_W)*DATA_W-1:0] lat_data,
  input  logic [(1<<PAGE_W)-1:0]        lat_mask,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_undef
);
  localparam int NB    = 1 << PAGE_W;
  localparam int DEPTH = MEM_PAGES * NB;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] mem   [DEPTH];
  logic              undef [DEPTH];
  logic [PG_W-1:0]   slot;
  logic [IDX_W-1:0]  rd_idx;

  assign slot   = page % PG_W'(MEM_PAGES);
  assign rd_idx = IDX_W'(rd_addr % ADDR_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i]   <= '1;
        undef[i] <= 1'b1;
      end
    end else if (commit) begin
      for (int b = 0; b < NB; b++) begin
        mem[IDX_W'(slot) * IDX_W'(NB) + IDX_W'(b)] <=
          lat_mask[b] ? lat_data[b*DATA_W +: DATA_W] : '1;
        undef[IDX_W'(slot) * IDX_W'(NB) + IDX_W'(b)] <= !lat_mask[b];
      end
    end
  end

  assign rd_data  = mem[rd_idx];
  assign rd_undef = undef[rd_idx];
endmodule

// File: rtl/page_program_timer.sv
module page_program_timer
  import pgm_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 6,
  parameter int MEM_PAGES = 4,
  parameter int MIN_W     = 2,
  parameter int IDLE_TO   = 30,
  parameter int PROG_CYC  = 60,
  parameter int LOCK_CYC  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_undef,
  output logic              busy,
  output logic              page_err
);
  localparam int NB   = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;

  logic              strobe, end_ok, accept, lat_we, commit;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [PG_W-1:0]   cur_page;
  pgm_state_e        state;
  logic [NB*DATA_W-1:0] lat_data;
  logic [NB-1:0]     lat_mask;

  pgm_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_W(MIN_W)) u_pins (
    .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .din,
    .strobe, .end_ok, .cap_addr, .cap_data
  );

  pgm_ctrl #(.PG_W(PG_W), .IDLE_TO(IDLE_TO), .PROG_CYC(PROG_CYC),
             .LOCK_CYC(LOCK_CYC)) u_ctrl (
    .clk, .rst_n, .supply_ok, .strobe, .end_ok,
    .cap_page(cap_addr[ADDR_W-1:PAGE_W]),
    .state, .cur_page, .accept, .lat_we, .commit, .busy, .page_err
  );

  pgm_page_latch #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_latch (
    .clk, .rst_n, .we(lat_we), .ofs(cap_addr[PAGE_W-1:0]), .wdata(cap_data),
    .clr(commit), .lat_data, .lat_mask
  );

  pgm_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                  .MEM_PAGES(MEM_PAGES)) u_mem (
    .clk, .rst_n, .commit, .page(cur_page), .lat_data, .lat_mask,
    .rd_addr, .rd_data, .rd_undef
  );
endmodule

// File: rtl/pgm_checker.sv
module pgm_checker
  import pgm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       busy,
  input logic       page_err,
  input logic       lat_we,
  input logic       commit,
  input pgm_state_e state
);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  p_supply_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> ##1 !$rose(busy));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(lat_we));

  p_prog_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |-> !lat_we);

  p_commit_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit));
endmodule

bind page_program_timer pgm_checker u_chk (
  .clk, .rst_n, .supply_ok, .busy, .page_err, .lat_we, .commit, .state
);

// File: tb/page_program_timer_bench.sv
`timescale 1ns/1ps
module page_program_timer_bench;
  localparam int IDLE_TO  = 30;
  localparam int PROG_CYC = 60;
  localparam int LOCK_CYC = 40;
  localparam int MIN_W    = 2;
  localparam int FALL_AT  = IDLE_TO + PROG_CYC + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        supply_ok = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0, rd_addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  rd_data;
  logic        rd_undef, busy, page_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  page_program_timer #(.MIN_W(MIN_W), .IDLE_TO(IDLE_TO), .PROG_CYC(PROG_CYC),
                       .LOCK_CYC(LOCK_CYC)) u_page_program_timer (
    .clk, .rst_n, .supply_ok, .ce_n, .oe_n, .we_n, .addr, .din,
    .rd_addr, .rd_data, .rd_undef, .busy, .page_err
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_byte(input logic [14:0] a, input logic [7:0] exp_d,
                          input logic exp_u, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data == exp_d, tag, rd_data, exp_d);
    chk(rd_undef == exp_u, tag, rd_undef, exp_u);
  endtask

  // Strobe of w clocks; address/data switch to a1/d1 after the first clock.
  task automatic strobe(input logic [14:0] a0, input logic [7:0] d0,
                        input logic [14:0] a1, input logic [7:0] d1,
                        input int w, input logic oe, input logic ce);
    @(posedge clk); #1;
    addr = a0; din = d0; oe_n = oe; ce_n = ce; we_n = 1'b0;
    for (int i = 0; i < w; i++) begin
      @(posedge clk); #1;
      if (i == 0) begin addr = a1; din = d1; end
    end
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    strobe(a, d, a, d, 3, 1'b1, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Cycles from the current point (just after a release) until busy is low.
  task automatic to_idle(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk); #1;
      n++;
      if (!busy && n > 4) break;
    end
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R11 busy", busy, 0);
    chk(page_err == 1'b0, "R11 page_err", page_err, 0);
    chk_byte(15'h0000, 8'hFF, 1'b1, "R11 array");
    chk_byte(15'h00FF, 8'hFF, 1'b1, "R11 array top");
  endtask

  task automatic t_lockout;
    wr(15'h0004, 8'h11);
    idle(6);
    chk(busy == 1'b0, "R7 supply low", busy, 0);
    supply_ok = 1'b1;
    wr(15'h0004, 8'h22);
    idle(6);
    chk(busy == 1'b0, "R7 lockout", busy, 0);
    idle(LOCK_CYC + 5);
    chk_byte(15'h0004, 8'hFF, 1'b1, "R7 untouched");
  endtask

  task automatic t_qualify;
    strobe(15'h0008, 8'h33, 15'h0008, 8'h33, 3, 1'b0, 1'b0);
    idle(6);
    chk(busy == 1'b0, "R1 oe low", busy, 0);
    strobe(15'h0008, 8'h33, 15'h0008, 8'h33, 3, 1'b1, 1'b1);
    idle(6);
    chk(busy == 1'b0, "R1 ce high", busy, 0);
  endtask

  task automatic t_glitch;
    strobe(15'h0009, 8'h44, 15'h0009, 8'h44, MIN_W - 1, 1'b1, 1'b0);
    idle(6);
    chk(busy == 1'b0, "R8 short strobe", busy, 0);
  endtask

  task automatic t_basic;
    int n;
    wr(15'h0045, 8'hA5);
    idle(2);
    chk(busy == 1'b1, "R10 busy after load", busy, 1);
    wr(15'h0042, 8'h5A);
    wr(15'h007F, 8'h3C);
    wr(15'h0040, 8'h00);
    to_idle(n);
    chk(n == FALL_AT, "R4 busy fall timing", n, FALL_AT);
    chk_byte(15'h0045, 8'hA5, 1'b0, "R3 ofs 5");
    chk_byte(15'h0042, 8'h5A, 1'b0, "R3 ofs 2");
    chk_byte(15'h007F, 8'h3C, 1'b0, "R3 ofs 63");
    chk_byte(15'h0040, 8'h00, 1'b0, "R6 loaded zero");
    chk_byte(15'h0041, 8'hFF, 1'b1, "R6 unloaded");
    chk_byte(15'h0000, 8'hFF, 1'b1, "R3 other page");
  endtask

  task automatic t_window;
    int n;
    wr(15'h0083, 8'h71);
    idle(IDLE_TO - 8);
    chk(busy == 1'b1, "R4 window open", busy, 1);
    wr(15'h0084, 8'h72);
    to_idle(n);
    chk(n == FALL_AT, "R4 window restart", n, FALL_AT);
    chk_byte(15'h0083, 8'h71, 1'b0, "R4 first byte");
    chk_byte(15'h0084, 8'h72, 1'b0, "R4 second byte");
  endtask

  task automatic t_capture;
    int n;
    strobe(15'h00C1, 8'h10, 15'h00C2, 8'h20, 4, 1'b1, 1'b0);
    to_idle(n);
    chk_byte(15'h00C1, 8'h20, 1'b0, "R2 addr at start data at end");
    chk_byte(15'h00C2, 8'hFF, 1'b1, "R2 later addr unused");
  endtask

  task automatic t_prog_ignore;
    int n;
    wr(15'h000A, 8'h5E);
    idle(IDLE_TO + 10);
    chk(busy == 1'b1, "R5 in program", busy, 1);
    chk_byte(15'h000A, 8'hFF, 1'b1, "R5 not yet committed");
    wr(15'h000B, 8'h6F);
    n = IDLE_TO + 10 + 4;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk); #1;
      n++;
      if (!busy) break;
    end
    chk(n == FALL_AT, "R10 program not extended", n, FALL_AT);
    idle(IDLE_TO + 5);
    chk(busy == 1'b0, "R10 no new window", busy, 0);
    chk_byte(15'h000A, 8'h5E, 1'b0, "R5 committed");
    chk_byte(15'h000B, 8'hFF, 1'b1, "R10 ignored byte");
  endtask

  task automatic t_mismatch;
    int n;
    chk(page_err == 1'b0, "R9 no error yet", page_err, 0);
    wr(15'h0090, 8'h81);
    wr(15'h00D1, 8'h82);
    idle(2);
    chk(page_err == 1'b1, "R9 error set", page_err, 1);
    to_idle(n);
    chk_byte(15'h0090, 8'h81, 1'b0, "R9 window page written");
    chk_byte(15'h00D1, 8'hFF, 1'b1, "R9 other page dropped");
    idle(5);
    chk(page_err == 1'b1, "R9 sticky", page_err, 1);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_lockout();
    t_qualify();
    t_glitch();
    t_basic();
    t_window();
    t_capture();
    t_prog_ignore();
    t_mismatch();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule